// File: doc/BRIEF.md
# Receive Byte Queue with Threshold and Idle Timeout

This block is the receive-side byte queue of a 16550-style serial port. The receive shifter offers each finished byte on a push port; the register read path takes bytes from the head through a pop strobe. Bytes leave in the order they arrived. They are held in a 16-entry circular store with a read pointer, a write pointer and an occupancy count. Alongside the data the block reports four conditions. Data ready means the queue is non-empty. The threshold flag compares the occupancy with a selectable level. The overrun flag records a byte that was lost because the queue was full. The idle-timeout flag marks data that has sat untouched for four character periods.

Idle time is measured by a character-time tick that the baud logic supplies, so the block holds no knowledge of bit rates. A flush strobe empties the queue at once. A line-status read strobe clears the overrun flag. With queueing switched off (legacy single-byte mode) the store behaves as a one-entry holding register and the threshold is fixed at one byte.

Two small state machines carry the flags. The idle timer has three states. It starts in TMR_EMPTY. An accepted push moves it to TMR_COUNTING. The fourth idle tick moves it from TMR_COUNTING to TMR_EXPIRED. Any accepted push or pop moves it from TMR_COUNTING or TMR_EXPIRED back to TMR_COUNTING with the tick count cleared. A pop of the last byte, or a flush, moves it back to TMR_EMPTY. The overrun tracker has two states. A dropped push moves it from OVR_CLEAR to OVR_FLAGGED. A line-status read moves it from OVR_FLAGGED back to OVR_CLEAR.

Top module: `uart_rxq`

## Requirements
- R1: The queue holds up to 16 bytes. Bytes pop in push order. `count` equals the number of bytes held and updates on the clock edge that accepts the push or pop. `pop_data` always shows the oldest byte.
- R2: `data_ready` is 1 exactly when `count` is nonzero.
- R3: A push while the queue is full, with no pop in the same cycle, discards the byte and leaves the held contents and `count` unchanged. It sets `overrun` from the next cycle.
- R4: Once set, `overrun` stays 1 until a cycle with `lsr_rd` high, and reads 0 from the following cycle. If a byte is dropped in the same cycle as `lsr_rd`, the flag stays set.
- R5: `trig_sel` picks the threshold: 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14. `trig_hit` is 1 exactly when `count` is at least that level.
- R6: `timeout` rises after the fourth `char_tick` that arrives while data is held with no accepted push or pop, even below the threshold. Ticks while empty, or in the same cycle as an accepted push or pop, do not count.
- R7: An accepted pop clears `timeout` from the next cycle. Any accepted push or pop restarts the idle count from zero.
- R8: `flush` empties the queue in one cycle and clears `timeout`. A push or pop in the same cycle is ignored. `overrun` is unaffected.
- R9: A push and a pop in the same cycle on a non-empty queue leave `count` unchanged, including when the queue is full. The head byte leaves and the new byte joins the tail.
- R10: With `fifo_en` low the depth is one byte and the threshold is one byte whatever `trig_sel` holds. A second push before a pop is dropped as in R3.
- R11: A pop while the queue is empty is ignored: `count` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = 16-byte queueing, 0 = single-byte mode |
| trig_sel | input | 2 | Threshold select (1, 4, 8, 14 bytes) |
| flush | input | 1 | Empty the queue this cycle |
| push_valid | input | 1 | Byte offered by the receive shifter |
| push_data | input | 8 | Offered byte |
| pop | input | 1 | Data-register read strobe, removes the head byte |
| lsr_rd | input | 1 | Line-status read strobe, clears overrun |
| char_tick | input | 1 | One pulse per character period |
| pop_data | output | 8 | Oldest held byte |
| count | output | 5 | Bytes held |
| data_ready | output | 1 | Queue is non-empty |
| trig_hit | output | 1 | Count has reached the selected threshold |
| overrun | output | 1 | A byte was dropped since the last line-status read |
| timeout | output | 1 | Data left idle for four character periods |

## Verification
The bench fills the queue to all 16 entries and then pushes alone, and also pushes and pops together at full. A design that wrapped its pointers wrongly or let the count reach 17 would return corrupted or out-of-order bytes when the queue is drained. The idle timer is driven with exactly three and then four ticks, with a push in the middle of the window, and with ticks while empty. An off-by-one counter, a timer that ignores activity, or one that runs on an empty queue would raise the flag a tick early, late or spuriously. Overrun is checked to hold across idle cycles, to clear only on a line-status read, and to survive a flush and a clear that coincides with a new drop. Single-byte mode is checked to ignore a threshold of 14 and to drop a second byte.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef enum logic [1:0] {
        TMR_EMPTY    = 2'd0,
        TMR_COUNTING = 2'd1,
        TMR_EXPIRED  = 2'd2
    } tmr_state_t;

    typedef enum logic {
        OVR_CLEAR   = 1'b0,
        OVR_FLAGGED = 1'b1
    } ovr_state_t;

    // Threshold in bytes for each select code.
    function automatic int unsigned level_for(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              flush,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count,
    output logic              push_taken,
    output logic              pop_taken,
    output logic              push_dropped
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  eff_depth;
    logic              full;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        eff_depth    = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        full         = (count >= eff_depth);
        pop_taken    = pop && (count != '0) && !flush;
        push_taken   = push_valid && !flush && (!full || pop_taken);
        push_dropped = push_valid && !flush && full && !pop_taken;
        head_data    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (push_taken) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_taken) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_taken)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({push_taken, pop_taken})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
    import uart_rxq_pkg::*;
#(
    parameter int TOUT_CHARS = 4,
    localparam int TW = $clog2(TOUT_CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic push_taken,
    input  logic pop_taken,
    input  logic drain,
    input  logic char_tick,
    output logic timeout
);

    tmr_state_t    state_q, state_d;
    logic [TW-1:0] ticks_q, ticks_d;
    logic          activity;

    assign activity = push_taken || pop_taken;

    // next state
    always_comb begin
        state_d = state_q;
        ticks_d = ticks_q;
        unique case (state_q)
            TMR_EMPTY: begin
                if (push_taken) begin
                    state_d = TMR_COUNTING;
                    ticks_d = '0;
                end
            end
            TMR_COUNTING, TMR_EXPIRED: begin
                if (flush || drain) begin
                    state_d = TMR_EMPTY;
                    ticks_d = '0;
                end else if (activity) begin
                    state_d = TMR_COUNTING;
                    ticks_d = '0;
                end else if (char_tick && state_q == TMR_COUNTING) begin
                    if (ticks_q == TW'(TOUT_CHARS - 1)) begin
                        state_d = TMR_EXPIRED;
                    end else begin
                        ticks_d = ticks_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = TMR_EMPTY;
                ticks_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_EMPTY;
            ticks_q <= '0;
        end else begin
            state_q <= state_d;
            ticks_q <= ticks_d;
        end
    end

    // outputs
    always_comb begin
        timeout = (state_q == TMR_EXPIRED);
    end

endmodule

// File: rtl/rxq_overrun.sv
module rxq_overrun
    import uart_rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push_dropped,
    input  logic lsr_rd,
    output logic overrun
);

    ovr_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVR_CLEAR:   if (push_dropped) state_d = OVR_FLAGGED;
            OVR_FLAGGED: if (lsr_rd && !push_dropped) state_d = OVR_CLEAR;
            default:     state_d = OVR_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OVR_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        overrun = (state_q == OVR_FLAGGED);
    end

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 16,
    parameter int TOUT_CHARS = 4,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [1:0]        trig_sel,
    input  logic              flush,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              lsr_rd,
    input  logic              char_tick,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              data_ready,
    output logic              trig_hit,
    output logic              overrun,
    output logic              timeout
);

    logic             push_taken, pop_taken, push_dropped, drain;
    logic [CNT_W-1:0] level;

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .flush        (flush),
        .push_valid   (push_valid),
        .push_data    (push_data),
        .pop          (pop),
        .head_data    (pop_data),
        .count        (count),
        .push_taken   (push_taken),
        .pop_taken    (pop_taken),
        .push_dropped (push_dropped)
    );

    assign drain = pop_taken && !push_taken && (count == CNT_W'(1));

    rxq_idle_timer #(.TOUT_CHARS(TOUT_CHARS)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push_taken (push_taken),
        .pop_taken  (pop_taken),
        .drain      (drain),
        .char_tick  (char_tick),
        .timeout    (timeout)
    );

    rxq_overrun i_ovr (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_dropped (push_dropped),
        .lsr_rd       (lsr_rd),
        .overrun      (overrun)
    );

    always_comb begin
        level      = fifo_en ? CNT_W'(level_for(trig_sel)) : CNT_W'(1);
        trig_hit   = (count >= level);
        data_ready = (count != '0);
    end

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             flush,
    input logic             push_valid,
    input logic             pop,
    input logic             lsr_rd,
    input logic [CNT_W-1:0] count,
    input logic             overrun,
    input logic             timeout
);

    logic full_now;
    assign full_now = fifo_en ? (count == CNT_W'(DEPTH)) : (count != '0);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R1

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full_now && !pop && !flush) |=> overrun); // R3

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !lsr_rd) |=> overrun); // R4

    AST_TOUT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (count != '0)); // R6

    AST_POP_CLEARS_TOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count != '0 && !flush) |=> !timeout); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !timeout)); // R8

    AST_PUSHPOP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && pop && count != '0 && !flush) |=> (count == $past(count))); // R9

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_valid && count == '0) |=> (count == '0)); // R11

endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .flush      (flush),
    .push_valid (push_valid),
    .pop        (pop),
    .lsr_rd     (lsr_rd),
    .count      (count),
    .overrun    (overrun),
    .timeout    (timeout)
);

// File: tb/test_uart_rxq.sv
module test_uart_rxq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] trig_sel = 2'd0;
    logic       flush = 1'b0, push_valid = 1'b0, pop = 1'b0, lsr_rd = 1'b0, char_tick = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic [7:0] pop_data;
    logic [4:0] count;
    logic       data_ready, trig_hit, overrun, timeout;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] expq [$];

    always #5 clk = ~clk;

    uart_rxq i_uart_rxq (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .flush(flush), .push_valid(push_valid), .push_data(push_data),
        .pop(pop), .lsr_rd(lsr_rd), .char_tick(char_tick),
        .pop_data(pop_data), .count(count), .data_ready(data_ready),
        .trig_hit(trig_hit), .overrun(overrun), .timeout(timeout)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compares each popped head byte with the scoreboard (R1, R9).
    always @(negedge clk) begin
        if (rst_n && pop && expq.size() > 0) begin
            n_checks++;
            if (pop_data !== expq[0]) begin
                n_fail++;
                $display("FAIL R1 pop order actual=%0h expected=%0h", pop_data, expq[0]);
            end
            void'(expq.pop_front());
        end
    end

    // Driver: one cycle of stimulus; pushes accepted bytes into the scoreboard.
    task automatic step(input logic pv, input logic [7:0] pd, input logic pp,
                        input logic fl, input logic lr, input logic tk);
        int eff;
        bit taken;
        eff = fifo_en ? 16 : 1;
        taken = pv && !fl && ((expq.size() < eff) || (pp && expq.size() > 0));
        push_valid = pv; push_data = pd; pop = pp; flush = fl; lsr_rd = lr; char_tick = tk;
        @(posedge clk); #1;
        push_valid = 0; pop = 0; flush = 0; lsr_rd = 0; char_tick = 0;
        if (fl) expq.delete();
        else if (taken) expq.push_back(pd);
    endtask

    task automatic push_b(input logic [7:0] d); step(1, d, 0, 0, 0, 0); endtask
    task automatic pop_b();                   step(0, 0, 1, 0, 0, 0); endtask
    task automatic tick();                    step(0, 0, 0, 0, 0, 1); endtask
    task automatic idle();                    step(0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        idle();
        check("R2 reset data_ready", data_ready, 0);
        check("R1 reset count", count, 0);
        check("R4 reset overrun", overrun, 0);
        check("R6 reset timeout", timeout, 0);

        // r11_: pop while empty
        pop_b();
        check("R11 empty pop count", count, 0);

        // R5 thresholds
        push_b(8'h10); push_b(8'h11); push_b(8'h12);
        check("R1 count after 3", count, 3);
        check("R2 data_ready", data_ready, 1);
        check("R5 level1 hit", trig_hit, 1);
        trig_sel = 2'd1; #1;
        check("R5 level4 below", trig_hit, 0);
        push_b(8'h13);
        check("R5 level4 reached", trig_hit, 1);
        trig_sel = 2'd2; #1;
        check("R5 level8 below", trig_hit, 0);
        trig_sel = 2'd1;
        pop_b(); pop_b();
        check("R5 drops below level", trig_hit, 0);

        // Fill to 16 then overflow (R3)
        for (int i = 0; i < 14; i++) push_b(8'h20 + 8'(i));
        check("R1 full count", count, 16);
        trig_sel = 2'd3; #1;
        check("R5 level14 hit", trig_hit, 1);
        push_b(8'hEE);
        check("R3 drop keeps count", count, 16);
        check("R3 overrun set", overrun, 1);
        idle(); idle();
        check("R4 overrun holds", overrun, 1);
        step(0, 0, 0, 0, 1, 0);
        check("R4 overrun cleared", overrun, 0);

        // r9_: push and pop at full
        step(1, 8'h77, 1, 0, 0, 0);
        check("R9 count steady at full", count, 16);
        check("R4 no drop on push+pop", overrun, 0);
        step(1, 8'h78, 1, 0, 0, 0);
        check("R9 count steady again", count, 16);

        // Drain all; monitor checks order and contents (R3 dropped byte absent)
        for (int i = 0; i < 16; i++) pop_b();
        check("R1 drained", count, 0);
        check("R2 drained data_ready", data_ready, 0);

        // R6 timeout
        push_b(8'hA1);
        tick(); tick(); tick();
        check("R6 no timeout after 3", timeout, 0);
        tick();
        check("R6 timeout after 4 below trigger", timeout, 1);
        pop_b();
        check("R7 pop clears timeout", timeout, 0);

        // R7 restart by push
        push_b(8'hB1);
        tick(); tick(); tick();
        push_b(8'hB2);
        tick(); tick(); tick();
        check("R7 restart after push", timeout, 0);
        tick();
        check("R7 timeout after restart", timeout, 1);
        pop_b();
        check("R7 pop leaves data, no timeout", timeout, 0);
        pop_b();
        repeat (6) tick();
        check("R6 empty ticks ignored", timeout, 0);

        // R8 flush
        for (int i = 0; i < 16; i++) push_b(8'h40 + 8'(i));
        push_b(8'hEF);
        check("R3 overrun before flush", overrun, 1);
        tick(); tick(); tick(); tick();
        check("R6 timeout at full", timeout, 1);
        step(1, 8'h55, 1, 1, 0, 0);
        check("R8 flush count", count, 0);
        check("R8 flush timeout", timeout, 0);
        check("R8 overrun kept", overrun, 1);
        step(0, 0, 0, 0, 1, 0);
        check("R4 clear", overrun, 0);

        // R10 single-byte mode
        fifo_en = 1'b0; trig_sel = 2'd3;
        push_b(8'hC1);
        check("R10 count one", count, 1);
        check("R10 trigger fixed at one", trig_hit, 1);
        step(1, 8'hC2, 0, 0, 1, 0);
        check("R10 second byte dropped", count, 1);
        check("R4 drop wins over clear", overrun, 1);
        pop_b();
        check("R10 empty after pop", count, 0);
        step(0, 0, 0, 0, 1, 0);
        check("R4 clear after drop", overrun, 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule